// File: doc/BRIEF.md
# Per-Pin Configurable Interrupt Detector

This block watches a bank of input pins and raises one interrupt request when any of them shows the condition software asked for. Every pin has its own control word. A 4-bit trigger code in that word chooses one of these conditions: nothing, a held low level, a held high level, a rising edge, a falling edge, or any edge. The pins are resynchronised to the block clock before detection. Edges are found by comparing each synchronised pin with its value one cycle earlier.

A detected condition sets that pin's bit in a shared pending-flag word. Software clears a bit by writing 1 to it, and writing 0 leaves the bit alone. If an event and a clear land in the same cycle, the event wins. A level condition that persists therefore keeps its flag set. The interrupt output is the OR of all pending flags. The register port is a plain single-cycle bus: a write commits on the rising edge where the write strobe is high, and read data follows the address combinationally. No data stream passes through the block, so the bus needs no back-pressure.

Top module: `pin_irq_detect`

## Requirements
- R1: After reset every trigger code is 0x0, every pending flag is 0 and `irq_o` is low.
- R2: Pin n's control word is at byte address 4·n. A write stores bits 19:16 as the trigger code. A read returns that code in bits 19:16 and zero in every other bit. Writing zero to the word masks the pin.
- R3: Trigger code 0x0 sets no flag, whatever the pin does. Every code other than 0x8, 0x9, 0xA, 0xB and 0xC (for example 0x5 or 0xF) behaves the same way.
- R4: Code 0x9 sets the flag on a 0→1 pin change and never on a 1→0 change. The flag is visible after the third rising clock edge that follows the pin change, and not after the second.
- R5: Code 0xA sets the flag on a 1→0 pin change and never on a 0→1 change, with the same latency as R4.
- R6: Code 0xB sets the flag on both 0→1 and 1→0 changes.
- R7: Code 0x8 flags a low pin and code 0xC flags a high pin. While the level persists, a write-1 clear leaves the flag set. Once the level is gone, a clear removes the flag.
- R8: The pending-flag word is at byte address 0xA0, and bit n belongs to pin n. Writing 1 to a bit clears it, and writing 0 to a bit leaves it unchanged. Writing all ones clears every flag.
- R9: When an event for a pin and a write-1 clear of that pin's flag fall on the same clock edge, the flag stays set.
- R10: `irq_o` is high exactly when at least one pending flag is set.
- R11: An event on pin n sets bit n only.
- R12: Unaligned addresses, addresses 0x80 to 0x9C and addresses above 0xA0 read as zero. Writes to them change no control word and no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 8 | Byte address of the register access |
| bus_wr_i | input | 1 | Write strobe, committed on the rising edge |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| pins_i | input | 32 | Asynchronous pin inputs |
| irq_o | output | 1 | OR of all pending flags |

## Verification
A pin change passes two synchroniser flops and then the flag register, so edge flags and `irq_o` are due after the third rising edge and must still be clear after the second. A level flag is due one edge after the trigger code is written, and a status or control write takes effect on the edge where its strobe is high. Every check samples on a falling edge a known number of edges after its stimulus, and each latency is checked on both sides. For the same-edge case, the clear write is aligned to the third edge after a pin change.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    TRIG_OFF  = 4'h0,
    TRIG_LOW  = 4'h8,
    TRIG_RISE = 4'h9,
    TRIG_FALL = 4'hA,
    TRIG_ANY  = 4'hB,
    TRIG_HIGH = 4'hC
  } trig_code_e;

  typedef struct packed {
    logic on_low;
    logic on_high;
    logic on_rise;
    logic on_fall;
  } trig_sel_t;

  // Unknown codes fall through to all-zero, i.e. disabled.
  function automatic trig_sel_t decode_trig(logic [MODE_W-1:0] code);
    trig_sel_t sel;
    sel = '0;
    case (code)
      TRIG_LOW:  sel.on_low  = 1'b1;
      TRIG_HIGH: sel.on_high = 1'b1;
      TRIG_RISE: sel.on_rise = 1'b1;
      TRIG_FALL: sel.on_fall = 1'b1;
      TRIG_ANY: begin
        sel.on_rise = 1'b1;
        sel.on_fall = 1'b1;
      end
      default: sel = '0;
    endcase
    return sel;
  endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= '0;
        else         stage_q[g] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= '0;
        else         stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/pin_trigger_cell.sv
module pin_trigger_cell
  import pin_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_we_i,
  input  logic [MODE_W-1:0] mode_wdata_i,
  input  logic              pin_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              evt_o
);

  logic [MODE_W-1:0] mode_q;
  logic              prev_q;
  trig_sel_t         sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= TRIG_OFF;
      prev_q <= 1'b0;
    end else begin
      if (mode_we_i) mode_q <= mode_wdata_i;
      prev_q <= pin_i;
    end
  end

  always_comb begin
    sel   = decode_trig(mode_q);
    evt_o = (sel.on_low  & ~pin_i)
          | (sel.on_high &  pin_i)
          | (sel.on_rise &  pin_i & ~prev_q)
          | (sel.on_fall & ~pin_i &  prev_q);
  end

  assign mode_o = mode_q;

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int NPINS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] set_i,
  input  logic [NPINS-1:0] clr_i,
  output logic [NPINS-1:0] flags_o,
  output logic             irq_o
);

  logic [NPINS-1:0] flags_q;

  // Set has priority over a simultaneous clear.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~clr_i) | set_i;
  end

  assign flags_o = flags_q;
  assign irq_o   = |flags_q;

endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect
  import pin_irq_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter int MODE_LSB    = 16,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'hA0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [NPINS-1:0]  pins_i,
  output logic              irq_o
);

  localparam int IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1;
  localparam logic [ADDR_W-1:0] CTL_LIMIT = ADDR_W'(NPINS);

  logic [NPINS-1:0]  pin_sync_v;
  logic [NPINS-1:0]  pin_evt;
  logic [NPINS-1:0]  flag_q;
  logic [NPINS-1:0]  clr_v;
  logic [MODE_W-1:0] mode_arr [NPINS];
  logic              ctl_hit;
  logic              stat_hit;
  logic [IDX_W-1:0]  pin_idx;
  logic [MODE_W-1:0] wr_mode;

  // Address decode
  assign ctl_hit  = (bus_addr_i[1:0] == 2'b00) && ((bus_addr_i >> 2) < CTL_LIMIT);
  assign stat_hit = (bus_addr_i == STATUS_ADDR);
  assign pin_idx  = bus_addr_i[2 +: IDX_W];
  assign wr_mode  = bus_wdata_i[MODE_LSB +: MODE_W];
  assign clr_v    = (bus_wr_i && stat_hit) ? bus_wdata_i[NPINS-1:0] : '0;

  pin_sync #(
    .WIDTH  (NPINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pins_i),
    .sync_o  (pin_sync_v)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic we;
    assign we = bus_wr_i && ctl_hit && (pin_idx == IDX_W'(p));

    pin_trigger_cell u_cell (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .mode_we_i    (we),
      .mode_wdata_i (wr_mode),
      .pin_i        (pin_sync_v[p]),
      .mode_o       (mode_arr[p]),
      .evt_o        (pin_evt[p])
    );
  end

  irq_flag_bank #(
    .NPINS (NPINS)
  ) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (pin_evt),
    .clr_i   (clr_v),
    .flags_o (flag_q),
    .irq_o   (irq_o)
  );

  // Read mux
  always_comb begin
    bus_rdata_o = '0;
    if (ctl_hit) begin
      bus_rdata_o[MODE_LSB +: MODE_W] = mode_arr[pin_idx];
    end else if (stat_hit) begin
      bus_rdata_o[NPINS-1:0] = flag_q;
    end
  end

  logic unused_bus;
  assign unused_bus = ^bus_wdata_i;

endmodule

// File: rtl/pin_irq_detect_chk.sv
module pin_irq_detect_chk #(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'hA0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_wr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic              irq_o,
  input logic [NPINS-1:0]  flag_q,
  input logic [NPINS-1:0]  pin_evt
);

  // R1
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |=> (flag_q == '0));

  // R9
  evt_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flag_q & $past(pin_evt)) == $past(pin_evt)));

  // R8
  w1c_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == STATUS_ADDR) |=>
      ((flag_q & $past(bus_wdata_i[NPINS-1:0]) & ~$past(pin_evt)) == '0));

  // R3
  no_spurious_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(pin_evt)) == '0));

  // R10
  irq_matches_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == STATUS_ADDR) |-> (irq_o == (bus_rdata_o != '0)));

endmodule

bind pin_irq_detect pin_irq_detect_chk #(
  .NPINS       (NPINS),
  .ADDR_W      (ADDR_W),
  .DATA_W      (DATA_W),
  .STATUS_ADDR (STATUS_ADDR)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_addr_i  (bus_addr_i),
  .bus_wr_i    (bus_wr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .irq_o       (irq_o),
  .flag_q      (flag_q),
  .pin_evt     (pin_evt)
);

// File: tb/tb_pin_irq_detect.sv
module tb_pin_irq_detect;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] STAT = 8'hA0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pins = '0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_irq_detect dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bus_addr_i  (addr),
    .bus_wr_i    (wr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .pins_i      (pins),
    .irq_o       (irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wn(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bwr(logic [7:0] a, logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic brd(logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic set_mode(int p, logic [3:0] m);
    bwr(8'(p * 4), {12'h0, m, 16'h0});
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq", {31'b0, irq}, 32'h0);
    brd(STAT, d);            chk("R1 status", d, 32'h0);
    brd(8'h00, d);           chk("R1 ctl0", d, 32'h0);
    brd(8'h7C, d);           chk("R1 ctl31", d, 32'h0);
  endtask

  task automatic t_ctl_rw();
    logic [31:0] d;
    bwr(8'h0C, 32'hFFFF_FFFF);
    brd(8'h0C, d);           chk("R2 only code bits", d, 32'h000F_0000);
    bwr(8'h7C, 32'h0009_0000);
    brd(8'h7C, d);           chk("R2 ctl31", d, 32'h0009_0000);
    bwr(8'h0C, 32'h0);
    bwr(8'h7C, 32'h0);
    brd(8'h0C, d);           chk("R2 masked", d, 32'h0);
  endtask

  task automatic t_off_modes();
    logic [31:0] d;
    logic [3:0] codes [3] = '{4'h0, 4'h5, 4'hF};
    foreach (codes[i]) begin
      set_mode(4, codes[i]);
      pins[4] = 1'b1; wn(4);
      pins[4] = 1'b0; wn(4);
      brd(STAT, d);          chk("R3 disabled code", d, 32'h0);
    end
    set_mode(4, 4'h0);
  endtask

  task automatic t_rise();
    logic [31:0] d;
    set_mode(7, 4'h9);
    pins[7] = 1'b1;
    wn(2);                   chk("R4 not before 3rd edge", {31'b0, irq}, 32'h0);
    wn(1);                   chk("R4 rise irq", {31'b0, irq}, 32'h1);
    brd(STAT, d);            chk("R11 only bit 7", d, 32'h0000_0080);
    bwr(STAT, 32'h80);
    pins[7] = 1'b0; wn(4);
    brd(STAT, d);            chk("R4 no flag on fall", d, 32'h0);
    set_mode(7, 4'h0);
  endtask

  task automatic t_fall();
    logic [31:0] d;
    set_mode(12, 4'hA);
    pins[12] = 1'b1; wn(4);
    brd(STAT, d);            chk("R5 no flag on rise", d, 32'h0);
    pins[12] = 1'b0;
    wn(2);                   chk("R5 not before 3rd edge", {31'b0, irq}, 32'h0);
    wn(1);
    brd(STAT, d);            chk("R5 fall flag", d, 32'h0000_1000);
    bwr(STAT, 32'hFFFF_FFFF);
    set_mode(12, 4'h0);
  endtask

  task automatic t_any();
    logic [31:0] d;
    set_mode(20, 4'hB);
    pins[20] = 1'b1; wn(3);
    brd(STAT, d);            chk("R6 rise", d, 32'h0010_0000);
    bwr(STAT, 32'h0010_0000);
    brd(STAT, d);            chk("R6 cleared", d, 32'h0);
    pins[20] = 1'b0; wn(3);
    brd(STAT, d);            chk("R6 fall", d, 32'h0010_0000);
    bwr(STAT, 32'h0010_0000);
    set_mode(20, 4'h0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    set_mode(1, 4'h8);
    wn(1);
    brd(STAT, d);            chk("R7 low level", d, 32'h2);
    bwr(STAT, 32'h2);
    brd(STAT, d);            chk("R7 low persists", d, 32'h2);
    pins[1] = 1'b1; wn(2);
    bwr(STAT, 32'h2);
    brd(STAT, d);            chk("R7 low gone cleared", d, 32'h0);
    set_mode(1, 4'h0);
    pins[0] = 1'b1; wn(3);
    set_mode(0, 4'hC);
    wn(1);
    brd(STAT, d);            chk("R7 high level", d, 32'h1);
    bwr(STAT, 32'h1);
    brd(STAT, d);            chk("R7 high persists", d, 32'h1);
    pins[0] = 1'b0; wn(2);
    bwr(STAT, 32'h1);
    brd(STAT, d);            chk("R7 high gone cleared", d, 32'h0);
    set_mode(0, 4'h0);
    pins[1] = 1'b0; wn(3);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    for (int p = 8; p <= 10; p++) set_mode(p, 4'h9);
    pins[10:8] = 3'b111; wn(3);
    brd(STAT, d);            chk("R11 three pins", d, 32'h0000_0700);
    bwr(STAT, 32'h0);
    brd(STAT, d);            chk("R8 zero write no effect", d, 32'h0000_0700);
    bwr(STAT, 32'h0000_0200);
    brd(STAT, d);            chk("R8 single clear", d, 32'h0000_0500);
    chk("R10 irq with flags", {31'b0, irq}, 32'h1);
    bwr(STAT, 32'hFFFF_FFFF);
    brd(STAT, d);            chk("R8 clear all", d, 32'h0);
    chk("R10 irq low", {31'b0, irq}, 32'h0);
    for (int p = 8; p <= 10; p++) set_mode(p, 4'h0);
    pins[10:8] = 3'b000; wn(3);
  endtask

  task automatic t_same_edge();
    logic [31:0] d;
    set_mode(22, 4'hB);
    pins[22] = 1'b1; wn(3);
    pins[22] = 1'b0; wn(2);
    bwr(STAT, 32'h0040_0000);  // lands on the 3rd edge after the fall
    brd(STAT, d);            chk("R9 event beats clear", d, 32'h0040_0000);
    bwr(STAT, 32'h0040_0000);
    brd(STAT, d);            chk("R9 later clear works", d, 32'h0);
    set_mode(22, 4'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    set_mode(5, 4'h9);
    pins[5] = 1'b1; wn(3);
    bwr(8'hA4, 32'hFFFF_FFFF);
    bwr(8'h84, 32'hFFFF_FFFF);
    bwr(8'h9C, 32'hFFFF_FFFF);
    bwr(8'h01, 32'hFFFF_FFFF);
    brd(STAT, d);            chk("R12 flag kept", d, 32'h0000_0020);
    brd(8'h84, d);           chk("R12 gap reads zero", d, 32'h0);
    brd(8'hA4, d);           chk("R12 high reads zero", d, 32'h0);
    brd(8'h01, d);           chk("R12 unaligned reads zero", d, 32'h0);
    brd(8'h00, d);           chk("R12 ctl0 untouched", d, 32'h0);
    bwr(STAT, 32'hFFFF_FFFF);
    set_mode(5, 4'h0);
    pins[5] = 1'b0; wn(3);
  endtask

  initial begin
    wn(3);
    rst_n = 1'b1;
    wn(1);
    t_reset();
    t_ctl_rw();
    t_off_modes();
    t_rise();
    t_fall();
    t_any();
    t_level();
    t_w1c();
    t_same_edge();
    t_unmapped();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule